// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Delayed Write Data

This block is a single-port synchronous static memory, by default 256 words of 18 bits split into two 9-bit byte lanes. It accepts a new access on every rising clock edge, in any mix of reads and writes, with no idle cycles between them. Read data is not registered on the way out. The word addressed at an edge appears on the output during the cycle that follows that edge.

A write supplies its address at one edge and its data and lane selects at the next edge. Because of this one-cycle offset, a write never competes with a read for the data bus, so the two can alternate every cycle. Three chip enables, a clock enable and an asynchronous output enable qualify the accesses. A 4-beat burst can be started at any address and then stepped with an advance input, in linear or interleaved order. The order is latched from a mode input while reset is held.

Top module: `ftsram_core`

## Requirements
- R1: A read loaded at a rising edge drives the stored word on `dout` during the following cycle, with `dout_en` high when `oe_n` is low.
- R2: Reads and writes may be issued on consecutive edges in any mix. Every read returns the word as left by all earlier writes.
- R3: At an edge with `clk_en` low, the block ignores every input. Array contents, the burst state, a pending write and the outputs all keep their values.
- R4: The data for a write loaded at edge N is taken from `din` at edge N+1, together with `bw_n`. Lane i (bits i*9+8 down to i*9) is updated only if `bw_n[i]` is 0.
- R5: A load cycle is a deselect unless `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A deselect performs no access, leaves `dout_en` low in the next cycle and ends any burst.
- R6: During the data phase of a write, `dout_en` is low whatever the level of `oe_n`.
- R7: With `burst_ilv`=0 latched at reset, each advance beat increments address bits [1:0] modulo 4 from the load address.
- R8: With `burst_ilv`=1 latched at reset, beat k uses address bits [1:0] equal to the starting bits XOR k. `burst_ilv` has no effect outside reset.
- R9: A read issued at the edge right after a write's address edge, to the same address, returns the newly written lanes merged with the unwritten stored lanes.
- R10: `oe_n` acts combinationally. Raising it mid-cycle drops `dout_en` at once, and lowering it restores the read data.
- R11: An advance (`adv`=1) keeps the read or write type of the last load and ignores the chip enables and `wr_n`. An advance with no live burst is a deselect.
- R12: While `rst_n` is low, `dout_en` is low. After reset, no burst is live.
- R13: Within a burst, address bits above bit 1 stay at their load value, so the burst wraps within its aligned group of 4 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; the burst order is sampled while it is low |
| clk_en | input | 1 | High to act on the edge, low to ignore it |
| burst_ilv | input | 1 | Burst order at reset: 0 linear, 1 interleaved |
| addr | input | 8 | Word address for load cycles |
| adv | input | 1 | 1 advance the burst, 0 load a new address |
| wr_n | input | 1 | Low for a write on a load cycle |
| bw_n | input | 2 | Active-low lane selects, sampled with the write data |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | 18 | Write data, sampled one edge after the write address |
| dout | output | 18 | Flow-through read data |
| dout_en | output | 1 | High when the bus should be driven with `dout` |

## Verification
The array is first filled by 256 back-to-back writes. Alternating read and write streams then show that the write-data offset never stalls or corrupts a neighbouring read. A read that directly follows a write to the same address separates a correct merge from a stale read, and lane-select patterns 00, 01, 10 and 11 show which lane each bit controls. Bursts start at offset 1 and are run under both orders, so the linear sequence 1,2,3,0 and the interleaved sequence 1,0,3,2 differ. Stalls placed inside bursts and between a write's address and its data, together with deselects on each chip enable and a long random mix, check that held edges and deselects change nothing.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;

   typedef enum logic {
      BURST_LINEAR     = 1'b0,
      BURST_INTERLEAVE = 1'b1
   } burst_order_e;

   // low address bits for a given beat of a 4-beat burst
   function automatic logic [1:0] burst_low(input logic [1:0]   start,
                                            input logic [1:0]   beat,
                                            input burst_order_e ord);
      return (ord == BURST_INTERLEAVE) ? (start ^ beat) : (start + beat);
   endfunction

endpackage

// File: rtl/ftsram_array.sv
module ftsram_array #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [LANES-1:0]          lane_en,
   input  logic [LANE_W*LANES-1:0]   wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [LANE_W*LANES-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   // one storage column per byte lane
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] col [DEPTH];

      always_ff @(posedge clk) begin
         if (we && lane_en[g])
            col[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = col[raddr];
   end

endmodule

// File: rtl/ftsram_ctrl.sv
module ftsram_ctrl
   import ftsram_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              burst_ilv,
   input  logic [ADDR_W-1:0] addr,
   input  logic              adv,
   input  logic              wr_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   output logic              ph_valid,
   output logic              ph_wr,
   output logic [ADDR_W-1:0] ph_addr
);
   localparam int BEAT_W = 2;

   burst_order_e      order_q;
   logic              live_q;
   logic              type_q;
   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] beat_nx;
   logic              sel;

   assign sel     = !cs1_n && cs2 && !cs3_n;
   assign beat_nx = beat_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         order_q  <= burst_order_e'(burst_ilv);
         live_q   <= 1'b0;
         type_q   <= 1'b0;
         base_q   <= '0;
         beat_q   <= '0;
         ph_valid <= 1'b0;
         ph_wr    <= 1'b0;
         ph_addr  <= '0;
      end else if (clk_en) begin
         if (!adv) begin
            if (sel) begin
               live_q   <= 1'b1;
               type_q   <= !wr_n;
               base_q   <= addr;
               beat_q   <= '0;
               ph_valid <= 1'b1;
               ph_wr    <= !wr_n;
               ph_addr  <= addr;
            end else begin
               live_q   <= 1'b0;
               ph_valid <= 1'b0;
               ph_wr    <= 1'b0;
            end
         end else if (live_q) begin
            beat_q   <= beat_nx;
            ph_valid <= 1'b1;
            ph_wr    <= type_q;
            ph_addr  <= {base_q[ADDR_W-1:BEAT_W],
                         burst_low(base_q[BEAT_W-1:0], beat_nx, order_q)};
         end else begin
            ph_valid <= 1'b0;
            ph_wr    <= 1'b0;
         end
      end
   end

   // R3: an ignored edge changes nothing in the access pipeline
   p_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(ph_valid) && $stable(ph_wr) && $stable(ph_addr)));

   // R5: a load with any chip enable inactive starts no access
   p_deselect_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv && (cs1_n || !cs2 || cs3_n)) |=> !ph_valid);

   // R7: linear beats step the low address bits by one
   p_linear_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv && live_q && order_q == BURST_LINEAR)
      |=> ph_addr[BEAT_W-1:0] == $past(ph_addr[BEAT_W-1:0]) + 2'd1);

   // R11: advancing with no live burst is a deselect
   p_adv_idle_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv && !live_q) |=> !ph_valid);

   // R13: beats stay in the aligned group of four
   p_burst_block_r13 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv && live_q)
      |=> (ph_addr[ADDR_W-1:BEAT_W] == $past(ph_addr[ADDR_W-1:BEAT_W]))
          && (ph_addr[BEAT_W-1:0] != $past(ph_addr[BEAT_W-1:0])));

endmodule

// File: rtl/ftsram_core.sv
module ftsram_core #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clk_en,
   input  logic                     burst_ilv,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     adv,
   input  logic                     wr_n,
   input  logic [LANES-1:0]         bw_n,
   input  logic                     cs1_n,
   input  logic                     cs2,
   input  logic                     cs3_n,
   input  logic                     oe_n,
   input  logic [LANE_W*LANES-1:0]  din,
   output logic [LANE_W*LANES-1:0]  dout,
   output logic                     dout_en
);
   localparam int DATA_W = LANE_W * LANES;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ftsram_core: ADDR_W must be at least 3");
   end
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lane
      $error("ftsram_core: LANE_W and LANES must be positive");
   end

   logic              ph_valid;
   logic              ph_wr;
   logic [ADDR_W-1:0] ph_addr;
   logic              commit;
   logic [DATA_W-1:0] rdata;

   ftsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .burst_ilv (burst_ilv),
      .addr      (addr),
      .adv       (adv),
      .wr_n      (wr_n),
      .cs1_n     (cs1_n),
      .cs2       (cs2),
      .cs3_n     (cs3_n),
      .ph_valid  (ph_valid),
      .ph_wr     (ph_wr),
      .ph_addr   (ph_addr)
   );

   // write data arrives at the edge that closes the write's data phase
   assign commit = rst_n && clk_en && ph_valid && ph_wr;

   ftsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .clk     (clk),
      .we      (commit),
      .waddr   (ph_addr),
      .lane_en (~bw_n),
      .wdata   (din),
      .raddr   (ph_addr),
      .rdata   (rdata)
   );

   assign dout    = rdata;
   assign dout_en = ph_valid && !ph_wr && !oe_n;

   // R6: the cycle after a write load never drives the bus
   p_wr_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv && !cs1_n && cs2 && !cs3_n && !wr_n) |=> !dout_en);

   // R1: a selected read load with output enabled drives the bus next cycle
   p_read_drive_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !adv && !cs1_n && cs2 && !cs3_n && wr_n) |=> (dout_en == !oe_n));

endmodule

// File: tb/ftsram_core_tb.sv
`timescale 1ns/100ps
module ftsram_core_tb;
   localparam int AW = 8;
   localparam int LW = 9;
   localparam int NL = 2;
   localparam int DW = LW * NL;

   typedef struct {
      logic          en;
      logic [DW-1:0] data;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b1;
   logic          burst_ilv = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          adv = 1'b0;
   logic          wr_n = 1'b1;
   logic [NL-1:0] bw_n = '1;
   logic          cs1_n = 1'b1;
   logic          cs2 = 1'b0;
   logic          cs3_n = 1'b1;
   logic          oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   always #2.5 clk = ~clk;

   ftsram_core #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .burst_ilv(burst_ilv),
      .addr(addr), .adv(adv), .wr_n(wr_n), .bw_n(bw_n),
      .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .oe_n(oe_n),
      .din(din), .dout(dout), .dout_en(dout_en)
   );

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   // reference model state
   logic [DW-1:0] ref_mem [256];
   logic          pend_v = 1'b0;
   logic [AW-1:0] pend_a;
   logic [NL-1:0] pend_bw;
   logic          b_live = 1'b0;
   logic [AW-1:0] b_base;
   logic [1:0]    b_cnt;
   logic          b_wr;
   logic          last_rd = 1'b0;
   logic [AW-1:0] last_a = '0;
   logic          mode_q = 1'b0;
   int            wseq = 0;

   task automatic report(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // driver: one clock edge worth of stimulus plus its expected output
   task automatic cyc(input logic en, input logic a_adv, input logic [2:0] cs,
                      input logic wr, input logic [AW-1:0] a, input logic [NL-1:0] bw,
                      input logic oe, input string tag);
      exp_t          it;
      logic          v;
      logic          w;
      logic [AW-1:0] pa;
      logic [DW-1:0] wd;
      @(negedge clk);
      clk_en = en; adv = a_adv; {cs1_n, cs2, cs3_n} = cs;
      wr_n = !wr; addr = a; oe_n = oe;
      if (!en) begin
         din  = DW'($urandom);
         bw_n = NL'($urandom);
         it.en   = last_rd && !oe;
         it.data = ref_mem[last_a];
      end else begin
         if (pend_v) begin
            wseq++;
            wd   = DW'(wseq * 18'h1357 + 18'h2a5);
            din  = wd;
            bw_n = pend_bw;
            for (int l = 0; l < NL; l++)
               if (!pend_bw[l]) ref_mem[pend_a][l*LW +: LW] = wd[l*LW +: LW];
            pend_v = 1'b0;
         end else begin
            din  = DW'($urandom);
            bw_n = NL'($urandom);
         end
         v = 1'b0; w = 1'b0; pa = a;
         if (!a_adv) begin
            if (cs == 3'b010) begin
               v = 1'b1; w = wr;
               b_live = 1'b1; b_base = a; b_cnt = 2'd0; b_wr = wr;
            end else begin
               b_live = 1'b0;
            end
         end else if (b_live) begin
            b_cnt = b_cnt + 2'd1;
            v = 1'b1; w = b_wr;
            pa = {b_base[AW-1:2], mode_q ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
         end
         if (v && w) begin
            pend_v = 1'b1; pend_a = pa; pend_bw = bw;
         end
         last_rd = v && !w;
         last_a  = pa;
         it.en   = last_rd && !oe;
         it.data = ref_mem[pa];
      end
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic rd(input logic [AW-1:0] a, input string t);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, a, 2'b00, 1'b0, t);
   endtask
   task automatic wrt(input logic [AW-1:0] a, input logic [NL-1:0] bw, input string t);
      cyc(1'b1, 1'b0, 3'b010, 1'b1, a, bw, 1'b0, t);
   endtask
   task automatic step(input logic [NL-1:0] bw, input string t);
      cyc(1'b1, 1'b1, 3'b010, 1'b0, '0, bw, 1'b0, t);
   endtask
   task automatic nop(input string t);
      cyc(1'b1, 1'b0, 3'b000, 1'b0, '0, 2'b00, 1'b0, t);
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0; burst_ilv = mode; clk_en = 1'b1; adv = 1'b0;
      {cs1_n, cs2, cs3_n} = 3'b000; wr_n = 1'b1; oe_n = 1'b0;
      repeat (2) begin
         @(posedge clk); #1;
         checks++;
         if (dout_en !== 1'b0) report("R12 reset output enable", DW'(dout_en), '0);
      end
      @(negedge clk);
      rst_n = 1'b1; mode_q = mode;
      b_live = 1'b0; pend_v = 1'b0; last_rd = 1'b0;
   endtask

   // monitor: compare each cycle's output with the queued expectation
   initial begin
      exp_t it;
      forever begin
         @(posedge clk); #1;
         if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (dout_en !== it.en)
               report({it.tag, " dout_en"}, DW'(dout_en), DW'(it.en));
            else if (it.en && dout !== it.data)
               report({it.tag, " dout"}, dout, it.data);
         end
      end
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      do_reset(1'b0);

      // R2: fill every word back to back
      for (int a = 0; a < 256; a++) wrt(AW'(a), 2'b00, "R2 fill");

      // R1 / R2: alternating reads and writes
      rd(8'h10, "R1 read");
      wrt(8'h11, 2'b00, "R2 write");
      rd(8'h12, "R2 read after write");
      wrt(8'h13, 2'b00, "R2 write");
      wrt(8'h14, 2'b00, "R2 write");
      rd(8'h11, "R2 read");
      rd(8'h13, "R2 read");
      rd(8'h14, "R2 read");

      // R9: read immediately after write to same address
      wrt(8'h20, 2'b00, "R9 write");
      rd(8'h20, "R9 bypass full");
      wrt(8'h21, 2'b10, "R9 write lane0");
      rd(8'h21, "R9 bypass merged");

      // R4: lane selects
      wrt(8'h22, 2'b01, "R4 lane1 only");
      wrt(8'h23, 2'b11, "R4 no lane");
      rd(8'h22, "R4 lane1");
      rd(8'h23, "R4 none written");

      // R6: write data phase with oe_n low stays undriven
      cyc(1'b1, 1'b0, 3'b010, 1'b1, 8'h24, 2'b00, 1'b0, "R6 write phase");
      rd(8'h24, "R6 readback");

      // R5: deselect on each chip enable, including a dropped write
      cyc(1'b1, 1'b0, 3'b110, 1'b0, 8'h10, 2'b00, 1'b0, "R5 cs1_n high");
      cyc(1'b1, 1'b0, 3'b000, 1'b0, 8'h10, 2'b00, 1'b0, "R5 cs2 low");
      cyc(1'b1, 1'b0, 3'b011, 1'b1, 8'h30, 2'b00, 1'b0, "R5 cs3_n high write");
      rd(8'h30, "R5 unwritten");

      // R3: stalled read, stalled write data, stalled burst
      rd(8'h05, "R3 read");
      cyc(1'b0, 1'b0, 3'b010, 1'b0, 8'h07, 2'b00, 1'b0, "R3 held read");
      cyc(1'b0, 1'b0, 3'b010, 1'b1, 8'h07, 2'b00, 1'b0, "R3 held read");
      wrt(8'h08, 2'b00, "R3 write");
      cyc(1'b0, 1'b0, 3'b010, 1'b0, 8'h09, 2'b00, 1'b0, "R3 stall before data");
      rd(8'h08, "R3 pending write kept");
      rd(8'h07, "R3 ignored write");

      // R7 / R13: linear bursts starting at offset 1
      wrt(8'h41, 2'b00, "R7 burst write");
      step(2'b00, "R11 advance write");
      step(2'b10, "R11 advance write");
      step(2'b00, "R11 advance write");
      rd(8'h41, "R7 burst read");
      step(2'b00, "R7 beat");
      cyc(1'b0, 1'b1, 3'b010, 1'b0, 8'h00, 2'b00, 1'b0, "R3 burst stall");
      step(2'b00, "R7 beat");
      step(2'b00, "R13 wrap beat");
      step(2'b00, "R13 second wrap");

      // R11: advance after a deselect does nothing
      nop("R5 deselect");
      step(2'b00, "R11 advance after deselect");
      rd(8'h42, "R11 readback");

      // R10: asynchronous output enable
      rd(8'h41, "R10 read");
      @(posedge clk); #2;
      oe_n = 1'b1; #0.2;
      checks++;
      if (dout_en !== 1'b0) report("R10 oe_n high", DW'(dout_en), '0);
      oe_n = 1'b0; #0.2;
      checks++;
      if (dout_en !== 1'b1 || dout !== ref_mem[8'h41]) report("R10 oe_n low", dout, ref_mem[8'h41]);

      // R8: mode input ignored outside reset
      @(negedge clk); burst_ilv = 1'b1;
      rd(8'h51, "R8 mode ignored");
      step(2'b00, "R8 still linear");
      step(2'b00, "R8 still linear");
      nop("R5 end");
      nop("R5 end");

      // R8: interleaved order after reset with burst_ilv=1
      do_reset(1'b1);
      rd(8'h61, "R8 ilv read");
      step(2'b00, "R8 ilv beat");
      step(2'b00, "R8 ilv beat");
      step(2'b00, "R8 ilv beat");
      wrt(8'h71, 2'b00, "R8 ilv write");
      step(2'b01, "R8 ilv write beat");
      step(2'b00, "R8 ilv write beat");
      step(2'b00, "R8 ilv write beat");
      rd(8'h70, "R8 check");
      rd(8'h71, "R8 check");
      rd(8'h72, "R8 check");
      rd(8'h73, "R8 check");

      // R2: random mix of everything
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         cyc((r[1:0] != 2'b00), r[2] & r[3],
             (r[5:4] == 2'b00) ? r[8:6] : 3'b010,
             r[9], r[17:10], r[19:18], r[20] & r[21], "R2 random");
      end
      nop("R2 end");
      nop("R2 end");
      repeat (3) @(posedge clk);
      #1;
      summary();
      $finish;
   end

endmodule